// File: doc/BRIEF.md
# Stalling Host-to-Microcontroller Mailbox

This block joins a host processor and a protection microcontroller through one shared data byte. Any host access to the mailbox stops the host: the block raises a halt request and flags the access to the microcontroller as a pending request, marked either as a host write or as a host read. The microcontroller polls a status port to find out which kind of request is waiting. It can read the shared byte or replace it. It lets the host run again by setting the release bit in its control port.

A host read takes two passes. The first pass stalls the host and asks the microcontroller for a byte. After the release, the host repeats the same read. That second pass returns the shared byte without stalling and re-arms the block, so the next read stalls again. Host writes always stall. Address decoding sits outside the block and arrives as a chip select. In the system this block serves, the host decodes the mailbox at I/O address 0xE0.

Top module: `stall_mailbox`

## Requirements
- R1: After reset the shared byte and the control register are 0x00, no request is pending, the halt output is low and the status port reads 0x0B.
- R2: A host write (chip select and write strobe) while not halted stores the host byte in the shared latch. From the next cycle the halt output is high and status bit 3 and bit 1 read 0 while bit 0 reads 1.
- R3: A host read while not halted and not on a retry pass sets halt from the next cycle. It marks the request as a read: status bits 3 and 0 read 0 and bit 1 reads 1. The shared byte is unchanged.
- R4: The first host read after a read stall is a retry pass. It does not set halt, and the read after it stalls again.
- R5: Status bits 7, 6, 5, 4 and 2 equal the same bits of the byte the microcontroller last wrote to its control port, from the cycle after that write.
- R6: A control write whose bit 2 is 1 while the stored bit 2 is 0 clears the pending request. The halt output is low from the next cycle and status bits 3, 1 and 0 read 1.
- R7: A control write with bit 2 at 1 when the stored bit 2 is already 1 leaves a pending request and the halt output unchanged.
- R8: A microcontroller data write replaces the shared byte from the next cycle. The host sees that byte on its data output, including on the retry pass.
- R9: Host strobes are ignored while the halt output is high: the shared byte, the request kind and the retry state keep their values.
- R10: If a host write and a microcontroller data write fall in the same cycle, the host byte is stored.
- R11: A control write with bit 2 at 0 never clears a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_cs | input | 1 | Mailbox chip select from the host address decode |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Shared byte presented to the host |
| host_halt | output | 1 | Stall request to the host, high while a request is pending |
| mcu_data_wr | input | 1 | Microcontroller write strobe for the shared byte |
| mcu_data_in | input | 8 | Byte written by the microcontroller |
| mcu_data_out | output | 8 | Shared byte as read by the microcontroller |
| mcu_ctl_wr | input | 1 | Microcontroller write strobe for the control port |
| mcu_ctl_in | input | 8 | Control byte; bit 2 rising releases the host |
| mcu_status | output | 8 | Status: bit 3 low = pending, bit 1 low = pending write, bit 0 low = pending read, other bits echo control |

## Verification
Every result of this block is registered once, so a strobe applied before a clock edge shows up in the halt output, the status port and both data outputs for the whole cycle that follows that edge. This applies to host accesses, microcontroller data writes and the release edge alike. The bench drives inputs and compares outputs at the falling edge. It holds a behavioural model that takes the same inputs at each rising edge, so each comparison falls exactly one edge after the stimulus that caused it. The retry pass and the held-high release bit get dedicated sequences, because they are where an extra or a missing stall cycle would appear.

// File: rtl/stall_mailbox_pkg.sv
package stall_mailbox_pkg;

  // Kind of request waiting for the microcontroller
  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_WRITE = 2'd1,
    REQ_READ  = 2'd2
  } req_kind_e;

  // Status and control bit positions (decoded by firmware)
  localparam int unsigned ST_PEND_BIT = 3;
  localparam int unsigned ST_WR_BIT   = 1;
  localparam int unsigned ST_RD_BIT   = 0;
  localparam int unsigned CTL_REL_BIT = 2;

  // Release fires only on a 0 -> 1 change of the release bit
  function automatic logic release_edge(input logic strobe,
                                        input logic old_bit,
                                        input logic new_bit);
    return strobe && !old_bit && new_bit;
  endfunction

endpackage

// File: rtl/mbox_req_tracker.sv
module mbox_req_tracker
  import stall_mailbox_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_acc,
  input  logic      rd_acc,
  input  logic      release_i,
  output req_kind_e kind_o,
  output logic      retry_o
);

  req_kind_e kind_q;
  logic      retry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= REQ_NONE;
      retry_q <= 1'b0;
    end else begin
      if (wr_acc)
        kind_q <= REQ_WRITE;
      else if (rd_acc && !retry_q)
        kind_q <= REQ_READ;
      else if (release_i)
        kind_q <= REQ_NONE;
      if (rd_acc)
        retry_q <= !retry_q;
    end
  end

  assign kind_o  = kind_q;
  assign retry_o = retry_q;

  // R3: a first-pass read becomes a pending read and arms the retry
  a_r3_read_request: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !retry_q) |=> (kind_q == REQ_READ) && retry_q);

  // R4: the retry pass raises no request and disarms the retry
  a_r4_retry_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && retry_q) |=> (kind_q == REQ_NONE) && !retry_q);

  // R6: release with no new access leaves nothing pending
  a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !wr_acc && !rd_acc) |=> (kind_q == REQ_NONE));

endmodule

// File: rtl/mbox_data_latch.sv
module mbox_data_latch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_byte,
  input  logic              mcu_we,
  input  logic [DATA_W-1:0] mcu_byte,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (host_we)
      data_q <= host_byte;
    else if (mcu_we)
      data_q <= mcu_byte;
  end

  assign data_o = data_q;

  // R10: host byte wins a same-cycle collision
  a_r10_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |=> data_q == $past(host_byte));

  // R8: lone microcontroller write lands in the latch
  a_r8_mcu_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_we && !host_we) |=> data_q == $past(mcu_byte));

endmodule

// File: rtl/mbox_ctl_reg.sv
module mbox_ctl_reg
  import stall_mailbox_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [DATA_W-1:0] ctl_byte,
  output logic [DATA_W-1:0] ctl_o,
  output logic              release_o
);

  logic [DATA_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctl_q <= '0;
    else if (ctl_we)
      ctl_q <= ctl_byte;
  end

  assign ctl_o     = ctl_q;
  assign release_o = release_edge(ctl_we, ctl_q[CTL_REL_BIT], ctl_byte[CTL_REL_BIT]);

  // R11: a control write with the release bit low never releases
  a_r11_low_no_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_byte[CTL_REL_BIT]) |-> !release_o);

endmodule

// File: rtl/stall_mailbox.sv
module stall_mailbox
  import stall_mailbox_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_halt,
  input  logic              mcu_data_wr,
  input  logic [DATA_W-1:0] mcu_data_in,
  output logic [DATA_W-1:0] mcu_data_out,
  input  logic              mcu_ctl_wr,
  input  logic [DATA_W-1:0] mcu_ctl_in,
  output logic [DATA_W-1:0] mcu_status
);

  localparam logic [DATA_W-1:0] FLAG_MASK =
    (DATA_W'(1) << ST_PEND_BIT) | (DATA_W'(1) << ST_WR_BIT) | (DATA_W'(1) << ST_RD_BIT);
  localparam logic [DATA_W-1:0] ECHO_MASK = ~FLAG_MASK;

  function automatic logic [DATA_W-1:0] compose_status(input logic [DATA_W-1:0] ctl,
                                                       input req_kind_e kind);
    logic [DATA_W-1:0] s;
    s = ctl & ECHO_MASK;
    s[ST_PEND_BIT] = (kind == REQ_NONE);
    s[ST_WR_BIT]   = (kind != REQ_WRITE);
    s[ST_RD_BIT]   = (kind != REQ_READ);
    return s;
  endfunction

  // Named internal events
  logic              host_wr_acc;
  logic              host_rd_acc;
  logic              rel_evt;
  logic              retry;
  req_kind_e         kind;
  logic [DATA_W-1:0] ctl_val;
  logic [DATA_W-1:0] shared_byte;

  assign host_wr_acc = host_cs && host_wr && !host_halt;
  assign host_rd_acc = host_cs && host_rd && !host_wr && !host_halt;

  mbox_req_tracker u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_acc    (host_wr_acc),
    .rd_acc    (host_rd_acc),
    .release_i (rel_evt),
    .kind_o    (kind),
    .retry_o   (retry)
  );

  mbox_data_latch #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_wr_acc),
    .host_byte (host_wdata),
    .mcu_we    (mcu_data_wr),
    .mcu_byte  (mcu_data_in),
    .data_o    (shared_byte)
  );

  mbox_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (mcu_ctl_wr),
    .ctl_byte  (mcu_ctl_in),
    .ctl_o     (ctl_val),
    .release_o (rel_evt)
  );

  assign host_halt    = (kind != REQ_NONE);
  assign host_rdata   = shared_byte;
  assign mcu_data_out = shared_byte;
  assign mcu_status   = compose_status(ctl_val, kind);

  // R2: a host write stalls the host and reports a write
  a_r2_write_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_acc |=> host_halt && !mcu_status[ST_WR_BIT] && mcu_status[ST_RD_BIT]);

  // R5: echoed status bits follow the last control write
  a_r5_status_echo: assert property (@(posedge clk) disable iff (!rst_n)
    mcu_ctl_wr |=> (mcu_status & ECHO_MASK) == ($past(mcu_ctl_in) & ECHO_MASK));

  // R7: release bit already high keeps the host stalled
  a_r7_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (host_halt && mcu_ctl_wr && ctl_val[CTL_REL_BIT]) |=> host_halt);

  // R9: while halted the host cannot change the shared byte
  a_r9_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (host_halt && !mcu_data_wr) |=> $stable(mcu_data_out));

  // R6: halt and pending flag agree
  a_r6_flag_matches_halt: assert property (@(posedge clk) disable iff (!rst_n)
    host_halt == !mcu_status[ST_PEND_BIT]);

endmodule

// File: tb/stall_mailbox_bench.sv
module stall_mailbox_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       host_halt;
  logic       mcu_data_wr = 1'b0;
  logic [7:0] mcu_data_in = 8'h00;
  logic [7:0] mcu_data_out;
  logic       mcu_ctl_wr = 1'b0;
  logic [7:0] mcu_ctl_in = 8'h00;
  logic [7:0] mcu_status;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int  m_data = 0, m_ctl = 0;
  bit  m_pend = 0, m_wrt = 0, m_retry = 0;

  always #10 clk = ~clk;

  stall_mailbox u_stall_mailbox (
    .clk(clk), .rst_n(rst_n),
    .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_halt(host_halt),
    .mcu_data_wr(mcu_data_wr), .mcu_data_in(mcu_data_in), .mcu_data_out(mcu_data_out),
    .mcu_ctl_wr(mcu_ctl_wr), .mcu_ctl_in(mcu_ctl_in), .mcu_status(mcu_status)
  );

  // Reference model: same inputs, evaluated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 0; m_ctl = 0; m_pend = 0; m_wrt = 0; m_retry = 0;
    end else begin
      bit was_pend;
      was_pend = m_pend;
      if (mcu_ctl_wr) begin
        if (((m_ctl >> 2) & 1) == 0 && mcu_ctl_in[2]) m_pend = 0;
        m_ctl = mcu_ctl_in;
      end
      if (!was_pend && host_cs && host_wr) begin
        m_data = host_wdata; m_pend = 1; m_wrt = 1;
      end else begin
        if (mcu_data_wr) m_data = mcu_data_in;
        if (!was_pend && host_cs && host_rd) begin
          if (m_retry) m_retry = 0;
          else begin m_pend = 1; m_wrt = 0; m_retry = 1; end
        end
      end
    end
  end

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int exp_st;
    exp_st = (m_ctl & 8'hF4) | (m_pend ? 0 : 8) | ((m_pend && m_wrt) ? 0 : 2)
           | ((m_pend && !m_wrt) ? 0 : 1);
    check("halt", int'(host_halt), int'(m_pend));
    check("status", int'(mcu_status), exp_st);
    check("host data", int'(host_rdata), m_data);
    check("mcu data", int'(mcu_data_out), m_data);
  endtask

  // One cycle: compare outputs at the falling edge, then drive next inputs
  task automatic step(input bit cs, input bit rd, input bit wr, input int hb,
                      input bit dwr, input int db, input bit cwr, input int cb);
    @(negedge clk);
    compare();
    host_cs = cs; host_rd = rd; host_wr = wr; host_wdata = 8'(hb);
    mcu_data_wr = dwr; mcu_data_in = 8'(db);
    mcu_ctl_wr = cwr; mcu_ctl_in = 8'(cb);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic hwrite(input int b); step(1, 0, 1, b, 0, 0, 0, 0); endtask
  task automatic hread();             step(1, 1, 0, 0, 0, 0, 0, 0); endtask
  task automatic mctl(input int b);   step(0, 0, 0, 0, 0, 0, 1, b); endtask
  task automatic mdata(input int b);  step(0, 0, 0, 0, 1, b, 0, 0); endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  initial begin
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check("R1 reset status", int'(mcu_status), 8'h0B);

    cur_req = "R2";
    hwrite(8'h5A);
    idle(3);
    check("R2 stored byte", int'(mcu_data_out), 8'h5A);

    cur_req = "R9";
    hwrite(8'h11);
    hread();
    idle(2);

    cur_req = "R11";
    mctl(8'h00);
    mctl(8'hA0);
    idle(2);
    check("R11 still halted", int'(host_halt), 1);

    cur_req = "R6";
    mctl(8'hA4);
    idle(2);
    check("R6 released", int'(host_halt), 0);

    cur_req = "R7";
    hwrite(8'h33);
    mctl(8'h54);
    idle(2);
    check("R7 held level", int'(host_halt), 1);
    mctl(8'h50);
    mctl(8'h54);
    idle(1);

    cur_req = "R3";
    hread();
    idle(2);
    check("R3 read kind", int'(mcu_status & 8'h0B), 8'h02);

    cur_req = "R8";
    mdata(8'hC3);
    mctl(8'h00);
    mctl(8'h04);
    idle(1);

    cur_req = "R4";
    hread();
    idle(1);
    check("R4 retry no stall", int'(host_halt), 0);
    check("R4 retry data", int'(host_rdata), 8'hC3);
    hread();
    idle(1);
    check("R4 stalls again", int'(host_halt), 1);
    mctl(8'h00);
    mctl(8'h04);
    hread();
    idle(1);

    cur_req = "R10";
    step(1, 0, 1, 8'h77, 1, 8'h88, 0, 0);
    idle(1);
    check("R10 host wins", int'(mcu_data_out), 8'h77);
    mctl(8'h00);
    mctl(8'h04);

    cur_req = "R5";
    mctl(8'hFF);
    idle(1);
    mctl(8'h00);
    mctl(8'h6B);
    mctl(8'h90);
    idle(2);

    finish_run();
  end

endmodule